// File: doc/BRIEF.md
# Bus-Matching Dual-Clock FIFO

This block is a one-way FIFO between two clock domains whose storage word is 80 bits wide. Each of its two ports picks, independently, a bus width of 80, 40, 20 or 10 bits. The write port packs narrow beats into whole 80-bit storage words. The read port splits storage words back into narrow beats. An endian select decides whether the first narrow beat of a storage word sits in its most-significant or its least-significant end. The read side places the beats in the same order on both ports.

Two read behaviours are offered. In standard mode a read request loads the next beat into the output register on the read clock edge, and the status output reports emptiness. In first-word fall-through mode the next beat is placed in the output register without any request, and the status output reports that a beat is waiting. On the write side, the status output reports fullness in standard mode and free room in fall-through mode. A retransmit input rewinds reading to the first word stored since reset. An active-low asynchronous reset clears both sides.

Top module: `busmatch_fifo`

## Requirements
- R1: Straight after reset, dataB is zero. In standard mode inFlag is 0 and outFlag is 1. In fall-through mode (fwftMode=1) inFlag is 1 and outFlag is 0.
- R2: sizeA encodes the port A width W: 0 gives 80, 1 gives 40, 2 gives 20, 3 gives 10. A beat is taken from dataA[W-1:0] and the upper bits are ignored. With bigEndian=0, the k-th beat of a storage word (k from 0) fills bits [k*W +: W].
- R3: With bigEndian=1, the k-th beat of a storage word fills bits [80-(k+1)*W +: W].
- R4: sizeB uses the same width encoding as sizeA. Storage words are read in the order they were written. The k-th read beat of a word returns the slice given by the same position rule, under bigEndian. It appears on dataB[W-1:0], with the upper bits of dataB at zero.
- R5: A storage word does not become readable until its last beat has been written. A partly packed word leaves the read side empty.
- R6: In standard mode, outFlag is 1 exactly when no whole word is left unread. The beat taken by a read appears on dataB after the clkB edge that accepts that read.
- R7: In fall-through mode, the next unread beat is shown on dataB with outFlag=1 and without any read. A read edge consumes that beat. outFlag drops to 0 when nothing more is stored.
- R8: The FIFO holds 2**DEPTH_LOG2 storage words. When it holds that many, inFlag is 1 in standard mode and 0 in fall-through mode. Beats written while it is full are dropped.
- R9: A read while empty has no effect. dataB keeps its value, and no stored word is skipped.
- R10: A port acts only on a clock edge of its own clock where both its chip select and its enable are 1.
- R11: retransmit=1 on a clkB edge makes reading start again at the first word written since reset.
- R12: rstN=0 clears both pointers and dataB, and discards a partly packed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkA | input | 1 | Write port clock |
| clkB | input | 1 | Read port clock |
| rstN | input | 1 | Asynchronous reset for both sides, active low |
| fwftMode | input | 1 | 1 selects first-word fall-through, 0 selects standard |
| bigEndian | input | 1 | 1: first beat in the top slice; 0: first beat in the bottom slice |
| sizeA | input | 2 | Write width select (0=80, 1=40, 2=20, 3=10) |
| csA | input | 1 | Write port select |
| enA | input | 1 | Write enable |
| dataA | input | 80 | Write beat, right-aligned |
| inFlag | output | 1 | Full (standard) or room available (fall-through) |
| sizeB | input | 2 | Read width select (0=80, 1=40, 2=20, 3=10) |
| csB | input | 1 | Read port select |
| enB | input | 1 | Read enable |
| retransmit | input | 1 | Rewinds reading to the first stored word |
| dataB | output | 80 | Read beat, right-aligned, upper bits zero |
| outFlag | output | 1 | Empty (standard) or beat waiting (fall-through) |

## Verification
The assertions assume that fwftMode, bigEndian, sizeA and sizeB are changed only while rstN is low. They also assume that a retransmit happens with the write port idle and with no more than 2**DEPTH_LOG2 words written since reset. Under those conditions, the gray-coded pointers change by single steps, or settle before they are used, and the fill levels seen in each domain stay within the storage depth. The bench sets every configuration inside a reset. It writes at most the storage depth between resets. It raises retransmit only after the write port has been quiet for several read clock cycles.

// File: rtl/busmatch_fifo_pkg.sv
package busmatch_fifo_pkg;
  localparam int unsigned WORD_W  = 80;
  localparam int unsigned LANE_W  = 10;
  localparam int unsigned LANES   = WORD_W / LANE_W;
  localparam int unsigned LIDX_W  = $clog2(LANES);
  localparam int unsigned SHIFT_W = $clog2(WORD_W);

  // Width code: 0 -> 80 bits, 1 -> 40, 2 -> 20, 3 -> 10
  typedef logic [1:0] busSize_t;

  typedef struct packed {
    logic               wrLoad;
    logic               wrCommit;
    logic [SHIFT_W-1:0] wrShift;
    logic [WORD_W-1:0]  wrMask;
    logic               rdLoad;
    logic [SHIFT_W-1:0] rdShift;
    logic [WORD_W-1:0]  rdMask;
  } strobe_t;

  // Index of the last beat of a storage word at this width
  function automatic logic [LIDX_W-1:0] lastLane(busSize_t s);
    return LIDX_W'((1 << s) - 1);
  endfunction

  // Bit offset of beat idx inside a storage word
  function automatic logic [SHIFT_W-1:0] laneShift(busSize_t s, logic [LIDX_W-1:0] idx, logic big);
    int w;
    w = int'(WORD_W >> s);
    if (big) return SHIFT_W'(int'(WORD_W) - (int'(idx) + 1) * w);
    return SHIFT_W'(int'(idx) * w);
  endfunction

  function automatic logic [WORD_W-1:0] laneMask(busSize_t s);
    return {WORD_W{1'b1}} >> (WORD_W - (WORD_W >> s));
  endfunction
endpackage

// File: rtl/busmatch_fifo_ctrl.sv
module busmatch_fifo_ctrl
  import busmatch_fifo_pkg::*;
#(
  parameter int unsigned DEPTH_LOG2  = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clkA,
  input  logic                  clkB,
  input  logic                  rstN,
  input  logic                  fwftMode,
  input  logic                  bigEndian,
  input  busSize_t              sizeA,
  input  busSize_t              sizeB,
  input  logic                  csA,
  input  logic                  enA,
  input  logic                  csB,
  input  logic                  enB,
  input  logic                  retransmit,
  output strobe_t               strobe,
  output logic [DEPTH_LOG2-1:0] wrAddr,
  output logic [DEPTH_LOG2-1:0] rdAddr,
  output logic                  inFlag,
  output logic                  outFlag
);
  localparam int unsigned PTR_W = DEPTH_LOG2 + 1;
  localparam int unsigned DEPTH = 1 << DEPTH_LOG2;

  function automatic logic [PTR_W-1:0] bin2gray(logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] gray2bin(logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = int'(PTR_W) - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- write domain ----------------
  logic [PTR_W-1:0]  wrPtr, wrGray, wrLevel;
  logic [LIDX_W-1:0] wrIdx;
  logic [PTR_W-1:0]  rdGraySyncA [SYNC_STAGES];
  logic              wrAccept, wrLast, wrFull;

  assign wrLevel  = wrPtr - gray2bin(rdGraySyncA[SYNC_STAGES-1]);
  assign wrFull   = (wrLevel == PTR_W'(DEPTH));
  assign wrLast   = (wrIdx == lastLane(sizeA));
  assign wrAccept = csA & enA & ~wrFull;

  always_ff @(posedge clkA or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      wrGray <= '0;
      wrIdx  <= '0;
    end else if (wrAccept) begin
      if (wrLast) begin
        wrIdx  <= '0;
        wrPtr  <= wrPtr + 1'b1;
        wrGray <= bin2gray(wrPtr + 1'b1);
      end else begin
        wrIdx <= wrIdx + 1'b1;
      end
    end
  end

  // ---------------- read domain ----------------
  logic [PTR_W-1:0]  rdPtr, rdGray, rdLevel;
  logic [LIDX_W-1:0] rdIdx;
  logic [PTR_W-1:0]  wrGraySyncB [SYNC_STAGES];
  logic              rdReq, rdEmpty, rdLoad, rdLast, outValid;

  always_ff @(posedge clkA or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < int'(SYNC_STAGES); i++) rdGraySyncA[i] <= '0;
    end else begin
      rdGraySyncA[0] <= rdGray;
      for (int i = 1; i < int'(SYNC_STAGES); i++) rdGraySyncA[i] <= rdGraySyncA[i-1];
    end
  end

  always_ff @(posedge clkB or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < int'(SYNC_STAGES); i++) wrGraySyncB[i] <= '0;
    end else begin
      wrGraySyncB[0] <= wrGray;
      for (int i = 1; i < int'(SYNC_STAGES); i++) wrGraySyncB[i] <= wrGraySyncB[i-1];
    end
  end

  assign rdLevel = gray2bin(wrGraySyncB[SYNC_STAGES-1]) - rdPtr;
  assign rdEmpty = (rdLevel == '0);
  assign rdReq   = csB & enB;
  assign rdLast  = (rdIdx == lastLane(sizeB));
  assign rdLoad  = ~retransmit & ~rdEmpty & (fwftMode ? (~outValid | rdReq) : rdReq);

  always_ff @(posedge clkB or negedge rstN) begin
    if (!rstN) begin
      rdPtr    <= '0;
      rdGray   <= '0;
      rdIdx    <= '0;
      outValid <= 1'b0;
    end else if (retransmit) begin
      rdPtr    <= '0;
      rdGray   <= '0;
      rdIdx    <= '0;
      outValid <= 1'b0;
    end else begin
      if (rdLoad) begin
        if (rdLast) begin
          rdIdx  <= '0;
          rdPtr  <= rdPtr + 1'b1;
          rdGray <= bin2gray(rdPtr + 1'b1);
        end else begin
          rdIdx <= rdIdx + 1'b1;
        end
      end
      if (rdLoad)     outValid <= 1'b1;
      else if (rdReq) outValid <= 1'b0;
    end
  end

  // ---------------- strobes and flags ----------------
  always_comb begin
    strobe.wrLoad   = wrAccept;
    strobe.wrCommit = wrAccept & wrLast;
    strobe.wrShift  = laneShift(sizeA, wrIdx, bigEndian);
    strobe.wrMask   = laneMask(sizeA);
    strobe.rdLoad   = rdLoad;
    strobe.rdShift  = laneShift(sizeB, rdIdx, bigEndian);
    strobe.rdMask   = laneMask(sizeB);
  end

  assign wrAddr  = wrPtr[DEPTH_LOG2-1:0];
  assign rdAddr  = rdPtr[DEPTH_LOG2-1:0];
  assign inFlag  = fwftMode ? ~wrFull : wrFull;
  assign outFlag = fwftMode ? outValid : rdEmpty;

  // ---------------- assertions ----------------
  p_level_bound_r8: assert property (@(posedge clkA) disable iff (!rstN)
    wrLevel <= PTR_W'(DEPTH))
    else $error("write-side fill level above depth");

  p_level_bound_r9: assert property (@(posedge clkB) disable iff (!rstN)
    rdLevel <= PTR_W'(DEPTH))
    else $error("read pointer ran past written data");

  p_pack_hold_r5: assert property (@(posedge clkA) disable iff (!rstN)
    (csA && enA && !wrLast) |=> $stable(wrPtr))
    else $error("word committed before last beat");

  p_idle_port_r10: assert property (@(posedge clkA) disable iff (!rstN)
    !(csA && enA) |=> ($stable(wrPtr) && $stable(wrIdx)))
    else $error("write port moved while not selected");

  p_empty_hold_r9: assert property (@(posedge clkB) disable iff (!rstN)
    (!fwftMode && rdEmpty && !retransmit) |=> $stable(rdPtr))
    else $error("read pointer moved while empty");

  p_fwft_hold_r7: assert property (@(posedge clkB) disable iff (!rstN)
    (fwftMode && outValid && !rdReq && !retransmit) |=> outValid)
    else $error("fall-through beat lost without a read");
endmodule

// File: rtl/busmatch_fifo_dp.sv
module busmatch_fifo_dp
  import busmatch_fifo_pkg::*;
#(
  parameter int unsigned DEPTH_LOG2 = 3
) (
  input  logic                  clkA,
  input  logic                  clkB,
  input  logic                  rstN,
  input  strobe_t               strobe,
  input  logic [DEPTH_LOG2-1:0] wrAddr,
  input  logic [DEPTH_LOG2-1:0] rdAddr,
  input  logic [WORD_W-1:0]     dataA,
  output logic [WORD_W-1:0]     dataB
);
  localparam int unsigned DEPTH = 1 << DEPTH_LOG2;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] packReg, merged, rdSlice;

  assign merged = (packReg & ~(strobe.wrMask << strobe.wrShift))
                | ((dataA & strobe.wrMask) << strobe.wrShift);

  always_ff @(posedge clkA or negedge rstN) begin
    if (!rstN)                packReg <= '0;
    else if (strobe.wrCommit) packReg <= '0;
    else if (strobe.wrLoad)   packReg <= merged;
  end

  always_ff @(posedge clkA) begin
    if (strobe.wrCommit) mem[wrAddr] <= merged;
  end

  assign rdSlice = (mem[rdAddr] >> strobe.rdShift) & strobe.rdMask;

  always_ff @(posedge clkB or negedge rstN) begin
    if (!rstN)              dataB <= '0;
    else if (strobe.rdLoad) dataB <= rdSlice;
  end
endmodule

// File: rtl/busmatch_fifo.sv
module busmatch_fifo
  import busmatch_fifo_pkg::*;
#(
  parameter int unsigned DEPTH_LOG2 = 3
) (
  input  logic        clkA,
  input  logic        clkB,
  input  logic        rstN,
  input  logic        fwftMode,
  input  logic        bigEndian,
  input  logic [1:0]  sizeA,
  input  logic        csA,
  input  logic        enA,
  input  logic [79:0] dataA,
  output logic        inFlag,
  input  logic [1:0]  sizeB,
  input  logic        csB,
  input  logic        enB,
  input  logic        retransmit,
  output logic [79:0] dataB,
  output logic        outFlag
);
  strobe_t               strobe;
  logic [DEPTH_LOG2-1:0] wrAddr, rdAddr;

  busmatch_fifo_ctrl #(.DEPTH_LOG2(DEPTH_LOG2)) ctrl_i (
    .clkA(clkA), .clkB(clkB), .rstN(rstN),
    .fwftMode(fwftMode), .bigEndian(bigEndian),
    .sizeA(sizeA), .sizeB(sizeB),
    .csA(csA), .enA(enA), .csB(csB), .enB(enB),
    .retransmit(retransmit),
    .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .inFlag(inFlag), .outFlag(outFlag)
  );

  busmatch_fifo_dp #(.DEPTH_LOG2(DEPTH_LOG2)) dp_i (
    .clkA(clkA), .clkB(clkB), .rstN(rstN),
    .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .dataA(dataA), .dataB(dataB)
  );
endmodule

// File: tb/busmatch_fifo_tb_top.sv
module busmatch_fifo_tb_top;
  localparam int DEPTH = 8;

  logic        clkA = 0, clkB = 0, rstN = 0;
  logic        fwftMode = 0, bigEndian = 0, csA = 0, enA = 0, csB = 0, enB = 0, retransmit = 0;
  logic [1:0]  sizeA = 0, sizeB = 0;
  logic [79:0] dataA = '0;
  logic [79:0] dataB;
  logic        inFlag, outFlag;

  int nChecks = 0, nFail = 0;
  bit done = 0;

  always #4 clkA = ~clkA;
  always #5 clkB = ~clkB;

  busmatch_fifo #(.DEPTH_LOG2(3)) dut_i (
    .clkA(clkA), .clkB(clkB), .rstN(rstN), .fwftMode(fwftMode), .bigEndian(bigEndian),
    .sizeA(sizeA), .csA(csA), .enA(enA), .dataA(dataA), .inFlag(inFlag),
    .sizeB(sizeB), .csB(csB), .enB(enB), .retransmit(retransmit),
    .dataB(dataB), .outFlag(outFlag)
  );

  function automatic logic [79:0] pat(int j);
    logic [31:0] a, b, c;
    a = 32'(j) * 32'h9E3779B1 + 32'h1357_2468;
    b = 32'(j) * 32'h7F4A7C15 + 32'hACE1_0F0F;
    c = 32'(j) * 32'h0001_2345 + 32'h0000_5A5A;
    return {a, b, c[15:0]};
  endfunction

  function automatic logic [79:0] expWord(int sa, int be, int base);
    logic [79:0] w, p;
    int wd;
    w = '0;
    wd = 80 >> sa;
    for (int k = 0; k < (1 << sa); k++) begin
      p = pat(base + k);
      for (int b = 0; b < wd; b++)
        w[be ? (80 - (k + 1) * wd + b) : (k * wd + b)] = p[b];
    end
    return w;
  endfunction

  function automatic logic [79:0] expSlice(logic [79:0] word, int sb, int be, int k);
    logic [79:0] r;
    int wd;
    r = '0;
    wd = 80 >> sb;
    for (int b = 0; b < wd; b++)
      r[b] = word[be ? (80 - (k + 1) * wd + b) : (k * wd + b)];
    return r;
  endfunction

  task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReset(input int sa, input int sb, input int be, input int fw);
    @(negedge clkA);
    rstN = 0;
    csA = 0; enA = 0; csB = 0; enB = 0; retransmit = 0;
    sizeA = 2'(sa); sizeB = 2'(sb); bigEndian = 1'(be); fwftMode = 1'(fw);
    repeat (3) @(negedge clkA);
    rstN = 1;
    repeat (3) @(negedge clkB);
  endtask

  task automatic wrBeat(input logic [79:0] d);
    @(negedge clkA);
    csA = 1; enA = 1; dataA = d;
    @(negedge clkA);
    csA = 0; enA = 0;
  endtask

  task automatic rdStd(output logic [79:0] q);
    @(negedge clkB);
    csB = 1; enB = 1;
    @(negedge clkB);
    csB = 0; enB = 0;
    q = dataB;
  endtask

  task automatic rdPulse();
    @(negedge clkB);
    csB = 1; enB = 1;
    @(negedge clkB);
    csB = 0; enB = 0;
  endtask

  task automatic settle();
    repeat (8) @(negedge clkB);
  endtask

  initial begin
    repeat (150000) @(posedge clkA);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog all requirements actual=timeout expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [79:0] q, w, hold;

    // R1: reset state, standard and fall-through
    doReset(0, 0, 0, 0);
    chk("R1 std inFlag", 80'(inFlag), 80'(0));
    chk("R1 std outFlag", 80'(outFlag), 80'(1));
    chk("R1 dataB", dataB, '0);
    doReset(0, 0, 0, 1);
    chk("R1 fwft inFlag", 80'(inFlag), 80'(1));
    chk("R1 fwft outFlag", 80'(outFlag), 80'(0));

    // R2 R3 R4 R6: every width pair and both endians, standard mode
    for (int sa = 0; sa < 4; sa++)
      for (int sb = 0; sb < 4; sb++)
        for (int be = 0; be < 2; be++) begin
          doReset(sa, sb, be, 0);
          for (int j = 0; j < 2 * (1 << sa); j++) wrBeat(pat(j));
          settle();
          chk("R6 not empty", 80'(outFlag), 80'(0));
          chk("R6 data before read", dataB, '0);
          for (int m = 0; m < 2; m++) begin
            w = expWord(sa, be, m * (1 << sa));
            for (int k = 0; k < (1 << sb); k++) begin
              rdStd(q);
              chk(be ? "R3 R4 big-endian beat" : "R2 R4 little-endian beat", q, expSlice(w, sb, be, k));
            end
          end
          chk("R6 empty after drain", 80'(outFlag), 80'(1));
        end

    // R7: fall-through for each read width and endian
    for (int sb = 0; sb < 4; sb++)
      for (int be = 0; be < 2; be++) begin
        doReset(0, sb, be, 1);
        wrBeat(pat(0));
        wrBeat(pat(1));
        settle();
        for (int m = 0; m < 2; m++)
          for (int k = 0; k < (1 << sb); k++) begin
            chk("R7 beat waiting", 80'(outFlag), 80'(1));
            chk("R7 beat shown without read", dataB, expSlice(pat(m), sb, be, k));
            rdPulse();
          end
        chk("R7 drained", 80'(outFlag), 80'(0));
      end

    // R5: partial word stays invisible
    doReset(3, 0, 0, 0);
    for (int j = 0; j < 7; j++) wrBeat(pat(j));
    settle();
    chk("R5 partial word hidden", 80'(outFlag), 80'(1));
    wrBeat(pat(7));
    settle();
    chk("R5 word visible after last beat", 80'(outFlag), 80'(0));
    rdStd(q);
    chk("R5 word content", q, expWord(3, 0, 0));

    // R8: full in standard mode, extra write dropped
    doReset(0, 0, 0, 0);
    for (int j = 0; j < DEPTH; j++) wrBeat(pat(20 + j));
    chk("R8 full flag", 80'(inFlag), 80'(1));
    wrBeat(pat(99));
    settle();
    for (int j = 0; j < DEPTH; j++) begin
      rdStd(q);
      chk("R8 stored word", q, pat(20 + j));
    end
    chk("R8 overflow beat dropped", 80'(outFlag), 80'(1));
    repeat (8) @(negedge clkA);
    chk("R8 not full after drain", 80'(inFlag), 80'(0));

    // R8: room indicator in fall-through mode
    doReset(0, 3, 0, 1);
    chk("R8 fwft room", 80'(inFlag), 80'(1));
    for (int j = 0; j < DEPTH; j++) wrBeat(pat(30 + j));
    chk("R8 fwft no room", 80'(inFlag), 80'(0));

    // R10: one of select/enable low does nothing
    doReset(0, 0, 0, 0);
    @(negedge clkA); csA = 1; enA = 0; dataA = pat(40);
    @(negedge clkA); csA = 0; enA = 1;
    @(negedge clkA); enA = 0;
    settle();
    chk("R10 write without both strobes", 80'(outFlag), 80'(1));
    wrBeat(pat(50));
    settle();
    @(negedge clkB); csB = 0; enB = 1;
    @(negedge clkB); csB = 1; enB = 0;
    @(negedge clkB); csB = 0;
    chk("R10 read without both strobes dataB", dataB, '0);
    chk("R10 read without both strobes flag", 80'(outFlag), 80'(0));
    rdStd(q);
    chk("R10 proper read", q, pat(50));

    // R9: read while empty has no effect
    hold = dataB;
    rdStd(q);
    chk("R9 dataB held on empty read", q, hold);
    wrBeat(pat(51));
    settle();
    rdStd(q);
    chk("R9 no word skipped", q, pat(51));

    // R11: retransmit
    doReset(0, 0, 0, 0);
    wrBeat(pat(60));
    wrBeat(pat(61));
    settle();
    rdStd(q);
    rdStd(q);
    chk("R11 second word before rewind", q, pat(61));
    chk("R11 empty before rewind", 80'(outFlag), 80'(1));
    @(negedge clkB); retransmit = 1;
    @(negedge clkB); retransmit = 0;
    settle();
    chk("R11 data again after rewind", 80'(outFlag), 80'(0));
    rdStd(q);
    chk("R11 first word again", q, pat(60));
    rdStd(q);
    chk("R11 second word again", q, pat(61));

    // R12: reset discards partial packing and clears output
    doReset(3, 0, 0, 0);
    for (int j = 0; j < 8; j++) wrBeat(pat(70 + j));
    settle();
    rdStd(q);
    chk("R12 setup word", q, expWord(3, 0, 70));
    for (int j = 0; j < 3; j++) wrBeat(pat(80 + j));
    doReset(3, 0, 0, 0);
    chk("R12 dataB cleared", dataB, '0);
    chk("R12 empty after reset", 80'(outFlag), 80'(1));
    for (int j = 0; j < 8; j++) wrBeat(pat(100 + j));
    settle();
    rdStd(q);
    chk("R12 partial beats discarded", q, expWord(3, 0, 100));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end
endmodule